// File: doc/BRIEF.md
# Bidirectional Warm Reset Sequencer

This block is the reset controller of a microcontroller and runs on the CPU clock. It watches two inputs: an active-low reset pin, and a power-detect level. From them it produces the internal reset, an active-low reset-out, an I/O tristate enable, a bus-abort pulse and a configuration-latch strobe.

A low level on the pin that lasts long enough starts a warm sequence. The sequence has these steps:

- A short flush window.
- A long internal phase. During this phase the block can pull the shared pin low itself, which makes the pin a bidirectional reset.
- A release of the pin, followed by a resample of it. The reset is stretched for as long as the pin stays low.
- A configuration-latch strobe, whose delay depends on the clock mode.
- The release of reset.

While power-detect is low, every reset is handled as a cold reset:

- The reset outputs are forced at once, with no clock needed.
- The pin pull-down is disabled.
- The timed phases are skipped.

Top module: `warm_reset_seq`

## Requirements
- R1: After the synchronous power-on reset `rst`, the outputs are idle: `int_rst_o`=0, `rst_out_n_o`=1, `io_tri_o`=0, `bus_abort_o`=0, `cfg_latch_o`=0, `pin_pull_o`=0 and `bidir_en_o`=0.
- R2: The pin passes through a two-stage synchronizer. A warm reset is accepted only after two consecutive synchronized low samples while idle. A single low sample is ignored.
- R3: On acceptance, `int_rst_o` and `io_tri_o` go to 1 and `rst_out_n_o` goes to 0, all in the cycle after the second low sample. `rst_out_n_o` is always the inverse of `int_rst_o`.
- R4: `bus_abort_o` is a one-cycle pulse in the first cycle after acceptance.
- R5: A 6-cycle flush window follows acceptance, then a 512-cycle internal phase. `pin_pull_o` is 1 during exactly those 512 cycles when `bidir_en_o` is 1.
- R6: After the internal phase, the pin is left undriven for 2 settle cycles. The sequencer then waits as long as the synchronized pin reads low.
- R7: Once the synchronized pin is seen high, `cfg_latch_o` pulses for one cycle. The pulse comes in the 3rd cycle when `presc_div2_i`=1 and in the 4th cycle otherwise.
- R8: `int_rst_o` and `io_tri_o` drop, and `rst_out_n_o` rises, in the cycle after the strobe.
- R9: A pulse on `bidir_set_i` sets `bidir_en_o`. `bidir_en_o` is cleared by `rst` and in the cycle after every strobe.
- R10: While `pwr_ok_i`=0, `int_rst_o` and `io_tri_o` are 1 and `pin_pull_o` is 0, in the same cycle and without waiting for a clock.
- R11: After a cold reset, the synchronized `pwr_ok_i` returning high leads straight to the pin wait of R6, then to R7 and R8, with no flush window or internal phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n_i | input | 1 | Level read back from the shared reset pin, active low |
| pwr_ok_i | input | 1 | Power-detect level; 0 forces cold reset handling |
| bidir_set_i | input | 1 | One-cycle request to arm the bidirectional pull-down |
| presc_div2_i | input | 1 | 1 when the clock runs in divide-by-2 prescaler mode |
| pin_pull_o | output | 1 | Drives the shared reset pin low when 1 |
| int_rst_o | output | 1 | Internal reset, active high |
| rst_out_n_o | output | 1 | Reset-out, active low |
| io_tri_o | output | 1 | Tristates the I/O pins when 1 |
| bus_abort_o | output | 1 | One-cycle request to abort the external bus cycle |
| cfg_latch_o | output | 1 | One-cycle configuration-latch strobe |
| bidir_en_o | output | 1 | Current state of the bidirectional-reset enable bit |

## Verification
A pin edge reaches the sequencer two clocks after it is sampled. So when a warm reset is accepted, the reset outputs change on the third clock after the first low sample. After that, each phase boundary is due at a fixed count: 6, 512, 2, then 3 or 4 cycles. The cold-reset outputs follow `pwr_ok_i` within the same cycle. The bench holds its own reference model, which advances on every rising edge, and compares every output at the falling edge. Inputs change 4 ns after a rising edge, so each comparison sees values that have settled. The same-cycle cold response is checked 1 ns after the input changes.

// File: rtl/warm_rst_pkg.sv
package warm_rst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_INTERN,
        ST_SETTLE,
        ST_EXTEND,
        ST_LATCH,
        ST_COLD
    } rst_state_e;

    typedef struct packed {
        logic int_rst;
        logic io_tri;
        logic bus_abort;
        logic cfg_latch;
        logic pin_pull;
    } rst_ctl_t;

    // Cycles from the high pin sample to the configuration strobe
    function automatic int unsigned latch_delay(input logic div2,
                                                input int unsigned d_div2,
                                                input int unsigned d_other);
        return div2 ? d_div2 : d_other;
    endfunction

endpackage

// File: rtl/wrs_sync.sv
module wrs_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= INIT;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{INIT}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wrs_fsm.sv
module wrs_fsm
    import warm_rst_pkg::*;
#(
    parameter int MIN_LOW    = 2,
    parameter int FLUSH_CYC  = 6,
    parameter int INTERN_CYC = 512,
    parameter int SETTLE_CYC = 2,
    parameter int LATCH_DIV2 = 3,
    parameter int LATCH_STD  = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_s_i,
    input  logic     pwr_s_i,
    input  logic     bidir_set_i,
    input  logic     div2_i,
    output rst_ctl_t ctl_o,
    output logic     bidir_en_o
);
    localparam int CNT_W = $clog2(INTERN_CYC + 1);
    localparam int LOW_W = $clog2(MIN_LOW + 1);

    rst_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [LOW_W-1:0] lowcnt;
    logic             bidir_en;
    logic [CNT_W-1:0] latch_last;
    logic             strobe;

    assign latch_last = CNT_W'(latch_delay(div2_i, LATCH_DIV2, LATCH_STD) - 1);
    assign strobe     = (state == ST_LATCH) && (cnt == latch_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            lowcnt   <= '0;
            bidir_en <= 1'b0;
        end else begin
            if (strobe)           bidir_en <= 1'b0;
            else if (bidir_set_i) bidir_en <= 1'b1;

            if (!pwr_s_i) begin
                state  <= ST_COLD;
                cnt    <= '0;
                lowcnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (!pin_s_i) begin
                            if (lowcnt == LOW_W'(MIN_LOW - 1)) begin
                                state  <= ST_FLUSH;
                                cnt    <= '0;
                                lowcnt <= '0;
                            end else begin
                                lowcnt <= lowcnt + 1'b1;
                            end
                        end else begin
                            lowcnt <= '0;
                        end
                    end
                    ST_FLUSH: begin
                        if (cnt == CNT_W'(FLUSH_CYC - 1)) begin
                            state <= ST_INTERN;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_INTERN: begin
                        if (cnt == CNT_W'(INTERN_CYC - 1)) begin
                            state <= ST_SETTLE;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_SETTLE: begin
                        if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
                            state <= ST_EXTEND;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_EXTEND: begin
                        if (pin_s_i) begin
                            state <= ST_LATCH;
                            cnt   <= '0;
                        end
                    end
                    ST_LATCH: begin
                        if (strobe) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_COLD: begin
                        state <= ST_EXTEND;
                        cnt   <= '0;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        ctl_o.int_rst   = (state != ST_IDLE);
        ctl_o.io_tri    = (state != ST_IDLE);
        ctl_o.bus_abort = (state == ST_FLUSH) && (cnt == '0);
        ctl_o.cfg_latch = strobe;
        ctl_o.pin_pull  = bidir_en && (state == ST_INTERN);
    end

    assign bidir_en_o = bidir_en;

    AST_ACCEPT_TWO_LOWS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH && $past(state) == ST_IDLE) |-> (!$past(pin_s_i) && !$past(pin_s_i, 2))); // R2
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl_o.bus_abort |=> !ctl_o.bus_abort); // R4
    AST_INTERN_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_INTERN && state != ST_INTERN) |-> ($past(cnt) == CNT_W'(INTERN_CYC - 1) || state == ST_COLD)); // R5
    AST_EXTEND_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXTEND && !pin_s_i && pwr_s_i) |=> (state == ST_EXTEND)); // R6
    AST_STROBE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.cfg_latch && pwr_s_i) |=> (state == ST_IDLE && !ctl_o.cfg_latch)); // R8
    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ctl_o.cfg_latch |=> !bidir_en); // R9
    AST_COLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !pwr_s_i |=> (state == ST_COLD)); // R11
endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq
    import warm_rst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2,
    parameter int FLUSH_CYC   = 6,
    parameter int INTERN_CYC  = 512,
    parameter int LATCH_DIV2  = 3,
    parameter int LATCH_STD   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin_n_i,
    input  logic pwr_ok_i,
    input  logic bidir_set_i,
    input  logic presc_div2_i,
    output logic pin_pull_o,
    output logic int_rst_o,
    output logic rst_out_n_o,
    output logic io_tri_o,
    output logic bus_abort_o,
    output logic cfg_latch_o,
    output logic bidir_en_o
);
    logic     pin_s;
    logic     pwr_s;
    rst_ctl_t ctl;

    wrs_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
        .clk (clk), .rst (rst), .d (rst_pin_n_i), .q (pin_s)
    );

    wrs_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pwr_sync (
        .clk (clk), .rst (rst), .d (pwr_ok_i), .q (pwr_s)
    );

    wrs_fsm #(
        .MIN_LOW    (MIN_LOW),
        .FLUSH_CYC  (FLUSH_CYC),
        .INTERN_CYC (INTERN_CYC),
        .SETTLE_CYC (SYNC_STAGES),
        .LATCH_DIV2 (LATCH_DIV2),
        .LATCH_STD  (LATCH_STD)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pin_s_i     (pin_s),
        .pwr_s_i     (pwr_s),
        .bidir_set_i (bidir_set_i),
        .div2_i      (presc_div2_i),
        .ctl_o       (ctl),
        .bidir_en_o  (bidir_en_o)
    );

    // Cold path bypasses the synchronizers and the clock
    assign int_rst_o   = ctl.int_rst | ~pwr_ok_i;
    assign io_tri_o    = ctl.io_tri  | ~pwr_ok_i;
    assign rst_out_n_o = ~int_rst_o;
    assign pin_pull_o  = ctl.pin_pull & pwr_ok_i;
    assign bus_abort_o = ctl.bus_abort;
    assign cfg_latch_o = ctl.cfg_latch;

    AST_NO_PULL_COLD: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok_i |-> !pin_pull_o); // R10
endmodule

// File: tb/warm_reset_seq_tb.sv
module warm_reset_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic pwr_ok = 1'b1;
    logic bidir_set = 1'b0;
    logic div2 = 1'b0;
    logic pin_pull, int_rst, rst_out_n, io_tri, bus_abort, cfg_latch, bidir_en;
    logic rst_pin_n;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign rst_pin_n = ~(ext_low | pin_pull);

    warm_reset_seq dut_i (
        .clk (clk), .rst (rst), .rst_pin_n_i (rst_pin_n), .pwr_ok_i (pwr_ok),
        .bidir_set_i (bidir_set), .presc_div2_i (div2),
        .pin_pull_o (pin_pull), .int_rst_o (int_rst), .rst_out_n_o (rst_out_n),
        .io_tri_o (io_tri), .bus_abort_o (bus_abort), .cfg_latch_o (cfg_latch),
        .bidir_en_o (bidir_en)
    );

    // Reference model: phase 0 idle, 1 flush, 2 internal, 3 settle, 4 pin wait, 5 latch, 6 cold
    int ph = 0, left = 0, lowrun = 0;
    bit m_s1 = 1, m_s2 = 1, m_p1 = 1, m_p2 = 1, m_ben = 0;

    always @(posedge clk) begin
        bit clr;
        started = 1;
        if (rst) begin
            ph = 0; left = 0; lowrun = 0;
            m_s1 = 1; m_s2 = 1; m_p1 = 1; m_p2 = 1; m_ben = 0;
        end else begin
            clr = (ph == 5 && left == 1);
            if (!m_p2) begin
                ph = 6; lowrun = 0;
            end else begin
                case (ph)
                    0: if (!m_s2) begin
                           lowrun++;
                           if (lowrun >= 2) begin ph = 1; left = 6; lowrun = 0; end
                       end else lowrun = 0;
                    1: begin left--; if (left == 0) begin ph = 2; left = 512; end end
                    2: begin left--; if (left == 0) begin ph = 3; left = 2; end end
                    3: begin left--; if (left == 0) ph = 4; end
                    4: if (m_s2) begin ph = 5; left = div2 ? 3 : 4; end
                    5: begin left--; if (left == 0) ph = 0; end
                    default: ph = 4;
                endcase
            end
            if (clr) m_ben = 0;
            else if (bidir_set) m_ben = 1;
            m_s2 = m_s1; m_s1 = rst_pin_n;
            m_p2 = m_p1; m_p1 = pwr_ok;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 int_rst", int_rst, (ph != 0) || !pwr_ok);
            chk("R3 rst_out_n", rst_out_n, !((ph != 0) || !pwr_ok));
            chk("R8 io_tri", io_tri, (ph != 0) || !pwr_ok);
            chk("R4 bus_abort", bus_abort, ph == 1 && left == 6);
            chk("R7 cfg_latch", cfg_latch, ph == 5 && left == 1);
            chk("R5 pin_pull", pin_pull, m_ben && ph == 2 && pwr_ok);
            chk("R9 bidir_en", bidir_en, m_ben);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1: idle outputs after power-on reset
        chk("R1 int_rst", int_rst, 1'b0);
        chk("R1 rst_out_n", rst_out_n, 1'b1);
        chk("R1 bidir_en", bidir_en, 1'b0);
        chk("R1 pin_pull", pin_pull, 1'b0);

        // R9: arm the pull-down
        bidir_set = 1'b1; step(1); bidir_set = 1'b0;
        step(2);
        chk("R9 set", bidir_en, 1'b1);

        // R2: one-cycle low pulse is ignored
        ext_low = 1'b1; step(1); ext_low = 1'b0;
        step(6);
        chk("R2 short pulse ignored", int_rst, 1'b0);

        // R5, R7 (div2 mode), R8: warm reset driving the pin itself
        div2 = 1'b1;
        ext_low = 1'b1; step(3); ext_low = 1'b0;
        step(100);
        chk("R5 pin pulled mid phase", pin_pull, 1'b1);
        step(440);
        chk("R8 released", int_rst, 1'b0);
        chk("R9 cleared at end", bidir_en, 1'b0);

        // R6, R7 (other mode): pin held low by the outside extends reset
        div2 = 1'b0;
        ext_low = 1'b1; step(600);
        chk("R6 extended", int_rst, 1'b1);
        ext_low = 1'b0; step(20);
        chk("R8 released after extension", int_rst, 1'b0);

        // R10, R11: cold reset from idle
        pwr_ok = 1'b0; #1;
        chk("R10 immediate int_rst", int_rst, 1'b1);
        chk("R10 immediate rst_out_n", rst_out_n, 1'b0);
        ext_low = 1'b1; step(10);
        pwr_ok = 1'b1; step(8);
        chk("R11 waits on pin", int_rst, 1'b1);
        ext_low = 1'b0; step(12);
        chk("R11 released", int_rst, 1'b0);

        // R10: cold reset interrupts the pull-down of a warm sequence
        bidir_set = 1'b1; step(1); bidir_set = 1'b0;
        ext_low = 1'b1; step(3); ext_low = 1'b0;
        step(100);
        chk("R5 pulling before cold", pin_pull, 1'b1);
        pwr_ok = 1'b0; #1;
        chk("R10 pull dropped", pin_pull, 1'b0);
        chk("R10 reset held", int_rst, 1'b1);
        step(10);
        pwr_ok = 1'b1; step(20);
        chk("R11 cold recovery", int_rst, 1'b0);
        chk("R9 cleared after cold", bidir_en, 1'b0);

        step(2);
        finish_run();
    end
endmodule